// File: doc/BRIEF.md
# Microprogram Sequencer with Dispatching Return Stack

This block produces the micro-address for the control store of a microcoded processor that executes two macroinstruction sets mixed in one program. Each cycle it reads three control fields of the current microinstruction: a next-address field, a call flag and a pop-after flag. From these it forms the following micro-address. Shared microroutines are entered by a call, which saves a return address on a small internal last-in-first-out stack. They are left with a pop, which resumes at the saved address.

Every macroinstruction routine ends with a pop. When that pop finds the stack empty, the macroinstruction is over. The sequencer then raises a one-cycle fetch request and holds its micro-address until the fetch side presents a valid instruction word. A predecoder inspects that word and classifies it as a legacy 16-bit or an extended 32-bit instruction. It then takes the entry address from the matching decode table. There is no mode register: the class is decided anew for every instruction.

Because a routine's closing pop returns to a caller whenever the stack is not empty, any macroinstruction routine can also be called as a subroutine of another one.

Top module: `useq_top`

## Requirements
- R1: After reset is released, `uaddr` is 0, `ovf_flag` is 0 and `fetch_next` is 1 in the first cycle, so the sequencer opens with a dispatch.
- R2: In the running state, with `ui_call` and `ui_pop` both 0, the micro-address of the next cycle equals `ui_next`.
- R3: In the running state, with `ui_call` 1 and the stack not full, the sequencer pushes `uaddr`+1 (modulo 2^12, so 0xFFF pushes 0x000) and the next micro-address is `ui_next`.
- R4: In the running state, with `ui_pop` 1, `ui_call` 0 and the stack not empty, the next micro-address is the most recently pushed address, which is then removed. Up to 8 nested calls return in reverse order.
- R5: In the running state, with `ui_pop` 1, `ui_call` 0 and the stack empty, `fetch_next` is 1 in the following cycle only and `uaddr` keeps its value. While the sequencer is not running, the control fields have no effect on `uaddr`, on the stack or on `ovf_flag`.
- R6: After the fetch request, `uaddr` holds for as many cycles as `instr_valid` stays 0. In the first cycle in which `instr_valid` is 1, the next micro-address is the decode entry of `instr_word`, and running resumes.
- R7: An instruction is extended when `instr_word[15:12]` is 4'hF and legacy otherwise. The legacy entry is 0x040 + 8*`instr_word[15:10]`. The extended entry is 0x800 + 16*`instr_word[21:16]`. All other bits are ignored.
- R8: A call made while the stack holds 8 entries sets `ovf_flag`, still jumps to `ui_next`, and leaves the 8 stored addresses unchanged.
- R9: When `ui_call` and `ui_pop` are both 1 in the running state, the call is performed and the pop is ignored.
- R10: `ovf_flag` stays 1 once set, through dispatches and returns, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Fetched macroinstruction word is valid |
| instr_word | input | 32 | Fetched macroinstruction word |
| fetch_next | output | 1 | One-cycle request for the next macroinstruction |
| ui_next | input | 12 | Next-address / call-target field of the current microinstruction |
| ui_call | input | 1 | Call flag of the current microinstruction |
| ui_pop | input | 1 | Pop-after flag of the current microinstruction |
| uaddr | output | 12 | Micro-address presented to the control store |
| ovf_flag | output | 1 | Sticky flag: a call was made with the stack full |

## Verification
The hardest condition to reach from the ports is a call issued with the stack full, followed by proof that the dropped push left the stored addresses untouched. The stimulus dispatches a routine and issues eight nested calls to distinct targets, then a ninth call. It then unwinds with nine pops: eight must return the original addresses in reverse order, and the ninth must end the macroinstruction. A second subtle case is that control fields are ignored while the sequencer waits. The bench holds call and pop active during the wait, then dispatches. An immediate pop must then end the macroinstruction, which shows that nothing was pushed.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SQ_RUN  = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  localparam logic [3:0] EXT_MARK = 4'hF;

  function automatic logic marks_extended(input logic [3:0] top_nibble);
    return top_nibble == EXT_MARK;
  endfunction

endpackage

// File: rtl/useq_predecode.sv
module useq_predecode
  import useq_pkg::*;
#(
  parameter int IW   = 32,
  parameter int UA_W = 12
) (
  input  logic [IW-1:0]   instr,
  output logic            is_ext,
  output logic [UA_W-1:0] entry
);

  localparam int OP_W     = 6;
  localparam int LEG_BASE = 'h040;
  localparam int LEG_SH   = 3;
  localparam int EXT_BASE = 'h800;
  localparam int EXT_SH   = 4;

  function automatic logic [UA_W-1:0] rom_legacy(input logic [OP_W-1:0] op);
    return UA_W'(LEG_BASE) + (UA_W'(op) << LEG_SH);
  endfunction

  function automatic logic [UA_W-1:0] rom_extended(input logic [OP_W-1:0] op);
    return UA_W'(EXT_BASE) + (UA_W'(op) << EXT_SH);
  endfunction

  logic [OP_W-1:0] leg_op;
  logic [OP_W-1:0] ext_op;
  logic            unused_bits;

  assign leg_op      = instr[15:10];
  assign ext_op      = instr[21:16];
  assign is_ext      = marks_extended(instr[15:12]);
  assign entry       = is_ext ? rom_extended(ext_op) : rom_legacy(leg_op);
  assign unused_bits = ^{instr[IW-1:22], instr[9:0]};

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign wr_idx = IDX_W'(count);
  assign rd_idx = empty ? '0 : IDX_W'(count - 1'b1);
  assign top    = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (push && !full) begin
      count <= count + 1'b1;
    end else if (pop && !empty) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[wr_idx] <= din;
    end
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int UA_W  = 12,
  parameter int DEPTH = 8,
  parameter int IW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [IW-1:0]   instr_word,
  output logic            fetch_next,
  input  logic [UA_W-1:0] ui_next,
  input  logic            ui_call,
  input  logic            ui_pop,
  output logic [UA_W-1:0] uaddr,
  output logic            ovf_flag
);

  function automatic logic [UA_W-1:0] link_addr(input logic [UA_W-1:0] a);
    return a + 1'b1;
  endfunction

  sq_state_e       state, state_d;
  logic [UA_W-1:0] uaddr_q, uaddr_d;
  logic            ovf_q;

  // named internal events, also observed by the bound checker
  logic            run;
  logic            ev_call, ev_push, ev_ovf, ev_ret, ev_end, ev_disp, ev_plain;
  logic            stk_empty, stk_full;
  logic [UA_W-1:0] stk_top;
  logic [UA_W-1:0] rom_entry;
  logic            rom_ext;

  assign run      = (state == SQ_RUN);
  assign ev_call  = run && ui_call;
  assign ev_push  = ev_call && !stk_full;
  assign ev_ovf   = ev_call && stk_full;
  assign ev_ret   = run && !ui_call && ui_pop && !stk_empty;
  assign ev_end   = run && !ui_call && ui_pop && stk_empty;
  assign ev_plain = run && !ui_call && !ui_pop;
  assign ev_disp  = !run && instr_valid;

  useq_predecode #(.IW(IW), .UA_W(UA_W)) u_pdec (
    .instr  (instr_word),
    .is_ext (rom_ext),
    .entry  (rom_entry)
  );

  useq_stack #(.DEPTH(DEPTH), .W(UA_W)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ev_push),
    .pop   (ev_ret),
    .din   (link_addr(uaddr_q)),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  always_comb begin
    state_d = state;
    unique case (state)
      SQ_RUN:  if (ev_end) state_d = SQ_REQ;
      SQ_REQ:  state_d = instr_valid ? SQ_RUN : SQ_WAIT;
      SQ_WAIT: if (instr_valid) state_d = SQ_RUN;
      default: state_d = SQ_REQ;
    endcase
  end

  always_comb begin
    uaddr_d = uaddr_q;
    if (ev_call || ev_plain) begin
      uaddr_d = ui_next;
    end else if (ev_ret) begin
      uaddr_d = stk_top;
    end else if (ev_disp) begin
      uaddr_d = rom_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_REQ;
      uaddr_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state   <= state_d;
      uaddr_q <= uaddr_d;
      if (ev_ovf) ovf_q <= 1'b1;
    end
  end

  assign uaddr      = uaddr_q;
  assign ovf_flag   = ovf_q;
  assign fetch_next = (state == SQ_REQ);

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int UA_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            fetch_next,
  input logic            instr_valid,
  input logic [UA_W-1:0] uaddr,
  input logic [UA_W-1:0] ui_next,
  input logic            ev_call,
  input logic            ev_end,
  input logic            ev_disp,
  input logic            ev_plain,
  input logic            stk_full,
  input logic            ovf_flag
);

  AST_PLAIN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_plain |=> uaddr == $past(ui_next));                      // R2

  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |=> uaddr == $past(ui_next));                       // R3

  AST_END_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> fetch_next && $stable(uaddr));                   // R5

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_next |=> !fetch_next);                                // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !instr_valid) |=> $stable(uaddr));                 // R6

  AST_DISP_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_disp |=> run);                                           // R6

  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_call && stk_full) |=> ovf_flag);                        // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);                                     // R10

endmodule

bind useq_top useq_chk #(.UA_W(UA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .fetch_next  (fetch_next),
  .instr_valid (instr_valid),
  .uaddr       (uaddr),
  .ui_next     (ui_next),
  .ev_call     (ev_call),
  .ev_end      (ev_end),
  .ev_disp     (ev_disp),
  .ev_plain    (ev_plain),
  .stk_full    (stk_full),
  .ovf_flag    (ovf_flag)
);

// File: tb/sim_useq_top.sv
module sim_useq_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [11:0] ui_next = '0;
  logic        ui_call = 1'b0;
  logic        ui_pop = 1'b0;
  logic        fetch_next;
  logic [11:0] uaddr;
  logic        ovf_flag;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  useq_top u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .fetch_next  (fetch_next),
    .ui_next     (ui_next),
    .ui_call     (ui_call),
    .ui_pop      (ui_pop),
    .uaddr       (uaddr),
    .ovf_flag    (ovf_flag)
  );

  // expected entry point, restated arithmetically from R7
  function automatic int exp_entry(input logic [31:0] w);
    if (((w >> 12) & 32'hF) == 32'd15) return 2048 + 16 * int'((w >> 16) & 32'h3F);
    return 64 + 8 * int'((w >> 10) & 32'h3F);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input int nxt, input bit c, input bit p);
    ui_next = 12'(nxt);
    ui_call = c;
    ui_pop  = p;
    tick();
  endtask

  task automatic dispatch(input logic [31:0] w);
    ui_call = 1'b0; ui_pop = 1'b0;
    instr_valid = 1'b1;
    instr_word  = w;
    tick();
    instr_valid = 1'b0;
    check("R7 entry", int'(uaddr), exp_entry(w));
    check("R6 resume", int'(fetch_next), 0);
  endtask

  task automatic end_instr();
    int held;
    held = int'(uaddr);
    drive(12'h000, 1'b0, 1'b1);
    ui_pop = 1'b0;
    check("R5 strobe", int'(fetch_next), 1);
    check("R5 hold", int'(uaddr), held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int ret_q [8];
    int cur;
    int held;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 fetch_next", int'(fetch_next), 1);
    check("R1 uaddr", int'(uaddr), 0);
    check("R1 ovf", int'(ovf_flag), 0);
    tick();
    check("R6 stall strobe", int'(fetch_next), 0);
    check("R6 stall addr", int'(uaddr), 0);
    repeat (3) tick();
    check("R6 stall long", int'(uaddr), 0);

    // R7 sweep over every legacy opcode (top nibble not F), junk in other bits
    for (int op = 0; op < 60; op++) begin
      dispatch({16'(op * 16'h1357), 6'(op), 10'((op * 37) & 1023)});
      end_instr();
    end
    // R7 sweep over every extended opcode
    for (int x = 0; x < 64; x++) begin
      dispatch({10'(x * 7), 6'(x), 4'hF, 12'((x * 85) & 4095)});
      end_instr();
    end

    // R2: plain sequencing
    dispatch(32'h0000_0400);
    for (int i = 0; i < 16; i++) begin
      drive((i * 12'h111) ^ 12'h05A, 1'b0, 1'b0);
      check("R2 next", int'(uaddr), ((i * 12'h111) ^ 12'h05A) & 12'hFFF);
    end

    // R3 / R4 / R8: fill the stack, overflow, unwind
    cur = int'(uaddr);
    for (int k = 0; k < 8; k++) begin
      ret_q[k] = (cur + 1) & 12'hFFF;
      cur = 12'h300 + k * 12'h021;
      drive(cur, 1'b1, 1'b0);
      check("R3 call target", int'(uaddr), cur);
    end
    check("R8 no ovf at 8", int'(ovf_flag), 0);
    drive(12'h777, 1'b1, 1'b0);
    check("R8 overflow jump", int'(uaddr), 12'h777);
    check("R8 ovf set", int'(ovf_flag), 1);
    for (int k = 7; k >= 0; k--) begin
      drive(12'h000, 1'b0, 1'b1);
      check("R4 lifo return", int'(uaddr), ret_q[k]);
      check("R8 no strobe", int'(fetch_next), 0);
    end
    end_instr();

    // R3: return address wraps modulo 2^12
    dispatch(32'h0000_0800);
    drive(12'hFFF, 1'b0, 1'b0);
    drive(12'h123, 1'b1, 1'b0);
    check("R3 wrap call", int'(uaddr), 12'h123);
    drive(12'h000, 1'b0, 1'b1);
    check("R3 wrap return", int'(uaddr), 0);
    end_instr();

    // R9: call and pop together -> call wins
    dispatch(32'h0000_0C00);
    cur = int'(uaddr);
    drive(12'h456, 1'b1, 1'b1);
    check("R9 call wins", int'(uaddr), 12'h456);
    check("R9 no strobe", int'(fetch_next), 0);
    drive(12'h000, 1'b0, 1'b1);
    check("R9 pushed", int'(uaddr), cur + 1);
    end_instr();

    // R5: fields ignored while waiting; nothing pushed
    held = int'(uaddr);
    ui_next = 12'hABC; ui_call = 1'b1; ui_pop = 1'b1;
    repeat (3) tick();
    check("R5 ignore addr", int'(uaddr), held);
    check("R5 ignore strobe", int'(fetch_next), 0);
    check("R10 ovf held", int'(ovf_flag), 1);
    dispatch(32'h0003_F000);
    end_instr();
    check("R10 ovf after dispatch", int'(ovf_flag), 1);

    // R10 / R1: only reset clears the flag
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    #1;
    check("R10 ovf cleared", int'(ovf_flag), 0);
    check("R1 restart strobe", int'(fetch_next), 1);
    check("R1 restart addr", int'(uaddr), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule